// File: doc/BRIEF.md
# Start-Up Configuration Sequencer

This block brings a clock-generator device out of power-up in a fixed order. While the power-good input is low, every output is held inactive. Once power-good rises, a counter holds the device in a power-on interval. When that interval ends, the block samples the strap pin once. A high strap gives the two shared pins the job of bank-select inputs. A low strap hands them to the two-wire serial port.

Next the block copies one of four stored configuration images, word by word, from a synchronous configuration store into the live register file. Only after the last word has been written does it raise a done flag, open the serial port (in the serial role) and ask the PLL to lock. A watchdog on the lock request raises an error flag if lock does not arrive in time. Once lock is seen, the strap pin is switched over to drive a reference clock.

Register writes that arrive from the serial engine are forwarded only while the port is open. Anything the host sets therefore overwrites the loaded image, and it has to be written again after every reset. The serial protocol engine itself sits outside this block.

Top module: `cfg_boot_seq`

## Requirements
- R1: While `pwr_good` is low, `store_rd_en`, `reg_wr_en`, `serial_en`, `pin_role_serial`, `boot_done`, `pll_lock_req`, `refclk_oe` and `lock_err` are all 0, whatever the other inputs are.
- R2: Counting cycles from the first rising clock edge after `pwr_good` rises, no store read happens before cycle POR_CYCLES+1. In that cycle the first read is issued.
- R3: In cycle POR_CYCLES the strap level and the select pins are sampled exactly once. With strap high, `pin_role_serial` stays 0 and the bank equals `sel_pins`. Later changes on `strap_in` or `sel_pins` have no effect until the next reset.
- R4: With strap low at the sampling cycle, `pin_role_serial` is 1 from the next cycle on, and bank 0 is loaded whatever the value of `sel_pins`.
- R5: The block reads store address {bank, i} for i = 0 to WORDS-1 in consecutive cycles, bank in the upper two bits. Each word is written to register address i exactly STORE_LAT cycles after its read, with the data the store returned.
- R6: `boot_done` rises in the cycle after the last image word is written, and it stays high until reset.
- R7: `serial_en` equals `boot_done` AND `pin_role_serial`. A serial write (`ser_wr_en`) appears on the register port, in the same cycle and with its address and data unchanged, only while `serial_en` is high. Otherwise it is dropped.
- R8: `pll_lock_req` rises together with `boot_done` and stays high.
- R9: `lock_err` rises after LOCK_TIMEOUT cycles in which lock is requested but neither `pll_locked` nor a previous lock was seen. It then stays high until reset, even if lock arrives later.
- R10: `refclk_oe` rises one cycle after a cycle in which `pll_lock_req` and `pll_locked` are both high, and stays high. `pll_locked` has no effect while no lock is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_good | input | 1 | Active-low asynchronous reset; low holds the power-on reset |
| strap_in | input | 1 | Strap pin level, sampled once at the end of the power-on interval |
| sel_pins | input | 2 | Shared pins used as bank select in the select role |
| store_rd_en | output | 1 | Read strobe to the configuration store |
| store_rd_addr | output | 2+log2(WORDS) | Store address {bank, word index} |
| store_rd_data | input | DATA_W | Store read data, STORE_LAT cycles after the strobe |
| ser_wr_en | input | 1 | Write request from the serial engine |
| ser_wr_addr | input | REG_AW | Serial write register address |
| ser_wr_data | input | DATA_W | Serial write data |
| reg_wr_en | output | 1 | Live register file write strobe |
| reg_wr_addr | output | REG_AW | Live register file write address |
| reg_wr_data | output | DATA_W | Live register file write data |
| pin_role_serial | output | 1 | Shared pins act as serial data and clock lines |
| serial_en | output | 1 | Serial port open for accesses |
| boot_done | output | 1 | Full image loaded |
| pll_lock_req | output | 1 | Request to the PLL to lock |
| pll_locked | input | 1 | Lock status from the PLL |
| lock_err | output | 1 | Lock did not arrive within LOCK_TIMEOUT cycles |
| refclk_oe | output | 1 | Strap pin now drives the reference clock |

## Verification
The hardest case to reach is a serial write that lands in the very cycle the port opens, right after the last image word. Close to it is the lock watchdog expiring and a late lock arriving afterwards. The bench drives a serial write on every cycle across the whole load window, so the first forwarded write falls exactly on the cycle `boot_done` rises. It also holds `pll_locked` low for LOCK_TIMEOUT cycles past the request and then raises it, which checks that the error stays set while the clock output still turns on. A further run holds lock high from reset, to show it is ignored before the request, and another cuts power in the middle of the load.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
   typedef enum logic [1:0] {
      BOOT_POR  = 2'd0,
      BOOT_LOAD = 2'd1,
      BOOT_UP   = 2'd2
   } boot_state_e;

   localparam int SEL_W = 2;
endpackage

// File: rtl/cbs_por_timer.sv
module cbs_por_timer #(
   parameter int CYCLES = 2500000
) (
   input  logic clk,
   input  logic rst_n,
   output logic expired
);
   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt_q;
   logic          exp_q;

   initial begin : elab_chk
      assert (CYCLES >= 2) else $error("CYCLES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (!exp_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CW'(CYCLES - 1)) exp_q <= 1'b1;
      end
   end

   assign expired = exp_q;

   p_expired_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q |=> exp_q);
endmodule

// File: rtl/cbs_image_copier.sv
module cbs_image_copier #(
   parameter int WORDS     = 16,
   parameter int DATA_W    = 8,
   parameter int BANK_W    = 2,
   parameter int REG_AW    = 8,
   parameter int STORE_LAT = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [BANK_W-1:0]             bank,
   output logic                          rd_en,
   output logic [BANK_W+$clog2(WORDS)-1:0] rd_addr,
   input  logic [DATA_W-1:0]             rd_data,
   output logic                          wr_en,
   output logic [REG_AW-1:0]             wr_addr,
   output logic [DATA_W-1:0]             wr_data,
   output logic                          done
);
   localparam int IDX_W = $clog2(WORDS);

   initial begin : elab_chk
      assert (WORDS >= 2 && (1 << IDX_W) == WORDS)
         else $error("WORDS must be a power of two, at least 2");
      assert (REG_AW >= IDX_W) else $error("REG_AW too narrow for WORDS");
      assert (STORE_LAT >= 1 && STORE_LAT <= 4) else $error("STORE_LAT out of range");
   end

   logic              active_q;
   logic [IDX_W-1:0]  idx_q;
   logic [BANK_W-1:0] bank_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         bank_q   <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         idx_q    <= '0;
         bank_q   <= bank;
      end else if (active_q) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == IDX_W'(WORDS - 1)) active_q <= 1'b0;
      end
   end

   assign rd_en   = active_q;
   assign rd_addr = {bank_q, idx_q};

   // align the write strobe and index with the store read latency
   logic             vld_pipe [STORE_LAT+1];
   logic [IDX_W-1:0] idx_pipe [STORE_LAT+1];

   assign vld_pipe[0] = active_q;
   assign idx_pipe[0] = idx_q;

   for (genvar s = 0; s < STORE_LAT; s++) begin : g_lat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_pipe[s+1] <= 1'b0;
            idx_pipe[s+1] <= '0;
         end else begin
            vld_pipe[s+1] <= vld_pipe[s];
            idx_pipe[s+1] <= idx_pipe[s];
         end
      end
   end

   assign wr_en   = vld_pipe[STORE_LAT];
   assign wr_addr = REG_AW'(idx_pipe[STORE_LAT]);
   assign wr_data = rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         done_q <= 1'b0;
      else if (vld_pipe[STORE_LAT] && idx_pipe[STORE_LAT] == IDX_W'(WORDS - 1))
         done_q <= 1'b1;
   end

   assign done = done_q;

   p_wr_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(rd_en, STORE_LAT));
   p_bank_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !start) |=> $stable(bank_q));
   p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q);
endmodule

// File: rtl/cbs_lock_watch.sv
module cbs_lock_watch #(
   parameter int TIMEOUT = 25000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic locked,
   output logic run,
   output logic err
);
   localparam int CW = $clog2(TIMEOUT + 1);

   initial begin : elab_chk
      assert (TIMEOUT >= 2) else $error("TIMEOUT must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic          err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (req && locked) run_q <= 1'b1;
         if (req && !locked && !run_q && !err_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(TIMEOUT - 1)) err_q <= 1'b1;
         end
      end
   end

   assign run = run_q;
   assign err = err_q;

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
   p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(req && !locked));
   p_run_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> $past(req && locked));
   p_run_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> run_q);
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
   import cbs_pkg::*;
#(
   parameter int POR_CYCLES   = 2500000,
   parameter int WORDS        = 16,
   parameter int DATA_W       = 8,
   parameter int REG_AW       = 8,
   parameter int STORE_LAT    = 1,
   parameter int LOCK_TIMEOUT = 25000
) (
   input  logic                           clk,
   input  logic                           pwr_good,
   input  logic                           strap_in,
   input  logic [1:0]                     sel_pins,
   output logic                           store_rd_en,
   output logic [1+$clog2(WORDS):0]       store_rd_addr,
   input  logic [DATA_W-1:0]              store_rd_data,
   input  logic                           ser_wr_en,
   input  logic [REG_AW-1:0]              ser_wr_addr,
   input  logic [DATA_W-1:0]              ser_wr_data,
   output logic                           reg_wr_en,
   output logic [REG_AW-1:0]              reg_wr_addr,
   output logic [DATA_W-1:0]              reg_wr_data,
   output logic                           pin_role_serial,
   output logic                           serial_en,
   output logic                           boot_done,
   output logic                           pll_lock_req,
   input  logic                           pll_locked,
   output logic                           lock_err,
   output logic                           refclk_oe
);
   localparam int BANK_W = SEL_W;

   boot_state_e        state_q;
   logic               por_done;
   logic               start;
   logic [BANK_W-1:0]  bank_pick;
   logic               role_serial_q;
   logic               latched_q;
   logic               ld_wr_en;
   logic [REG_AW-1:0]  ld_wr_addr;
   logic [DATA_W-1:0]  ld_wr_data;
   logic               ld_done;
   logic               run;
   logic               err;

   cbs_por_timer #(.CYCLES(POR_CYCLES)) u_por (
      .clk     (clk),
      .rst_n   (pwr_good),
      .expired (por_done)
   );

   // strap sampling: high strap keeps the pins as bank select
   assign start     = (state_q == BOOT_POR) && por_done;
   assign bank_pick = strap_in ? sel_pins : '0;

   always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good) begin
         state_q       <= BOOT_POR;
         role_serial_q <= 1'b0;
         latched_q     <= 1'b0;
      end else begin
         unique case (state_q)
            BOOT_POR: if (por_done) begin
               state_q       <= BOOT_LOAD;
               role_serial_q <= ~strap_in;
               latched_q     <= 1'b1;
            end
            BOOT_LOAD: if (ld_done) state_q <= BOOT_UP;
            default:   state_q <= state_q;
         endcase
      end
   end

   cbs_image_copier #(
      .WORDS(WORDS), .DATA_W(DATA_W), .BANK_W(BANK_W),
      .REG_AW(REG_AW), .STORE_LAT(STORE_LAT)
   ) u_copy (
      .clk     (clk),
      .rst_n   (pwr_good),
      .start   (start),
      .bank    (bank_pick),
      .rd_en   (store_rd_en),
      .rd_addr (store_rd_addr),
      .rd_data (store_rd_data),
      .wr_en   (ld_wr_en),
      .wr_addr (ld_wr_addr),
      .wr_data (ld_wr_data),
      .done    (ld_done)
   );

   cbs_lock_watch #(.TIMEOUT(LOCK_TIMEOUT)) u_lock (
      .clk    (clk),
      .rst_n  (pwr_good),
      .req    (ld_done),
      .locked (pll_locked),
      .run    (run),
      .err    (err)
   );

   assign serial_en       = ld_done & role_serial_q;
   assign reg_wr_en       = ld_wr_en | (serial_en & ser_wr_en);
   assign reg_wr_addr     = ld_wr_en ? ld_wr_addr : ser_wr_addr;
   assign reg_wr_data     = ld_wr_en ? ld_wr_data : ser_wr_data;
   assign pin_role_serial = role_serial_q;
   assign boot_done       = ld_done;
   assign pll_lock_req    = ld_done;
   assign refclk_oe       = run;
   assign lock_err        = err;

   p_no_read_in_por_r2: assert property (@(posedge clk) disable iff (!pwr_good)
      store_rd_en |-> (state_q != BOOT_POR));
   p_role_frozen_r3: assert property (@(posedge clk) disable iff (!pwr_good)
      latched_q |=> $stable(role_serial_q));
   p_ser_wr_open_r7: assert property (@(posedge clk) disable iff (!pwr_good)
      (reg_wr_en && !ld_wr_en) |-> (state_q != BOOT_POR && ld_done));
   p_req_after_last_r8: assert property (@(posedge clk) disable iff (!pwr_good)
      $rose(pll_lock_req) |-> $past(ld_wr_en));
   p_oe_after_lock_r10: assert property (@(posedge clk) disable iff (!pwr_good)
      $rose(refclk_oe) |-> $past(pll_lock_req && pll_locked));
endmodule

// File: tb/cfg_boot_seq_tb_top.sv
module cfg_boot_seq_tb_top;
   localparam int P  = 20;
   localparam int W  = 8;
   localparam int T  = 12;
   localparam int DW = 8;
   localparam int AW = 4;
   localparam int D  = P + W + 2;   // first cycle with boot_done high

   logic clk = 1'b0;
   always #2 clk = ~clk;            // 250 MHz

   logic          pwr_good = 1'b0;
   logic          strap_in = 1'b0;
   logic [1:0]    sel_pins = '0;
   logic          store_rd_en;
   logic [4:0]    store_rd_addr;
   logic [DW-1:0] store_rd_data;
   logic          ser_wr_en = 1'b0;
   logic [AW-1:0] ser_wr_addr = '0;
   logic [DW-1:0] ser_wr_data = '0;
   logic          reg_wr_en;
   logic [AW-1:0] reg_wr_addr;
   logic [DW-1:0] reg_wr_data;
   logic          pin_role_serial, serial_en, boot_done, pll_lock_req;
   logic          pll_locked = 1'b0;
   logic          lock_err, refclk_oe;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   cfg_boot_seq #(
      .POR_CYCLES(P), .WORDS(W), .DATA_W(DW), .REG_AW(AW),
      .STORE_LAT(1), .LOCK_TIMEOUT(T)
   ) dut_i (
      .clk(clk), .pwr_good(pwr_good), .strap_in(strap_in), .sel_pins(sel_pins),
      .store_rd_en(store_rd_en), .store_rd_addr(store_rd_addr),
      .store_rd_data(store_rd_data), .ser_wr_en(ser_wr_en),
      .ser_wr_addr(ser_wr_addr), .ser_wr_data(ser_wr_data),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .pin_role_serial(pin_role_serial), .serial_en(serial_en),
      .boot_done(boot_done), .pll_lock_req(pll_lock_req),
      .pll_locked(pll_locked), .lock_err(lock_err), .refclk_oe(refclk_oe)
   );

   function automatic logic [DW-1:0] img(int a);
      return DW'(a * 29 + 7);
   endfunction

   // configuration store, one cycle read latency
   always_ff @(posedge clk) begin
      if (store_rd_en) store_rd_data <= img(int'(store_rd_addr));
   end

   always @(posedge clk) cyc <= cyc + 1;

   task automatic report();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin : watchdog
      wait (cyc > 20000);
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=%0d expected<20000", cyc);
      report();
      $finish;
   end

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // R1: reset state with busy inputs
   task automatic reset_check();
      @(negedge clk);
      pwr_good = 1'b0; strap_in = 1'b1; sel_pins = 2'd3;
      ser_wr_en = 1'b1; pll_locked = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R1 store_rd_en",     store_rd_en,     0);
      chk("R1 reg_wr_en",       reg_wr_en,       0);
      chk("R1 serial_en",       serial_en,       0);
      chk("R1 pin_role_serial", pin_role_serial, 0);
      chk("R1 boot_done",       boot_done,       0);
      chk("R1 pll_lock_req",    pll_lock_req,    0);
      chk("R1 refclk_oe",       refclk_oe,       0);
      chk("R1 lock_err",        lock_err,        0);
   endtask

   task automatic drive(int sc, int n);
      case (sc)
         1: begin
            strap_in = (n <= P); sel_pins = (n <= P) ? 2'd2 : 2'd1;
            ser_wr_en = (n % 3 == 0); pll_locked = (n >= D + 5);
         end
         2: begin
            strap_in = (n > P); sel_pins = 2'd3;
            ser_wr_en = 1'b1; pll_locked = (n >= D + T + 6);
         end
         3: begin
            strap_in = 1'b1; sel_pins = 2'd1;
            ser_wr_en = (n % 2 == 1); pll_locked = 1'b1;
         end
         default: begin
            strap_in = 1'b0; sel_pins = 2'd2;
            ser_wr_en = 1'b1; pll_locked = 1'b0;
         end
      endcase
      ser_wr_addr = AW'(n);
      ser_wr_data = DW'(n + 100);
   endtask

   task automatic run_scn(int sc, int len);
      bit m_serial = 0;
      int m_bank = 0;
      bit m_run = 0, m_err = 0;
      int lcnt = 0;
      reset_check();
      drive(sc, 0);
      pwr_good = 1'b1;
      for (int n = 0; n < len; n++) begin
         bit e_rd, ld_w, done, e_sen, e_role, e_wr, n_run, n_err;
         int widx;
         drive(sc, n);
         #1;
         e_rd   = (n >= P + 1) && (n <= P + W);
         ld_w   = (n >= P + 2) && (n <= P + W + 1);
         widx   = n - P - 2;
         done   = (n >= D);
         e_sen  = done && m_serial;
         e_role = (n >= P + 1) && m_serial;
         e_wr   = ld_w || (e_sen && ser_wr_en);
         chk("R2 store_rd_en", store_rd_en, e_rd);
         if (e_rd) chk("R5 store_rd_addr", store_rd_addr, m_bank * W + (n - P - 1));
         chk("R7 reg_wr_en", reg_wr_en, e_wr);
         if (ld_w) begin
            chk("R5 reg_wr_addr", reg_wr_addr, widx);
            chk("R5 reg_wr_data", reg_wr_data, img(m_bank * W + widx));
         end else if (e_wr) begin
            chk("R7 fwd addr", reg_wr_addr, int'(ser_wr_addr));
            chk("R7 fwd data", reg_wr_data, int'(ser_wr_data));
         end
         chk("R3 R4 pin_role_serial", pin_role_serial, e_role);
         chk("R7 serial_en", serial_en, e_sen);
         chk("R6 boot_done", boot_done, done);
         chk("R8 pll_lock_req", pll_lock_req, done);
         chk("R9 lock_err", lock_err, m_err);
         chk("R10 refclk_oe", refclk_oe, m_run);
         if (n == P) begin
            m_serial = !strap_in;
            m_bank   = strap_in ? int'(sel_pins) : 0;
         end
         n_run = m_run || (done && pll_locked);
         n_err = m_err;
         if (done && !pll_locked && !m_run && !m_err) begin
            lcnt++;
            if (lcnt == T) n_err = 1;
         end
         m_run = n_run; m_err = n_err;
         @(posedge clk); @(negedge clk);
      end
   endtask

   initial begin
      run_scn(1, D + 15);      // select role, bank 2, lock after 5 cycles
      run_scn(2, D + T + 12);  // serial role, bank 0, timeout then late lock
      run_scn(3, D + 6);       // select role, bank 1, lock held from reset
      run_scn(4, P + 5);       // power lost mid-load
      reset_check();
      report();
      $finish;
   end
endmodule